// File: doc/BRIEF.md
# GPIO Bank Pin Ownership and Pad Control

This block is one bank of a general-purpose I/O controller. Each of its pins is owned either by the GPIO logic or by one of four internal peripheral functions. Software sets this up through a simple word-addressed register bus. GPIO ownership, output enable, output data, open-drain drive, pull-up and pull-down are each held in a state register. Each state register has a write-one-to-set address, a write-one-to-clear address and a read-only status address. Two read/write bit planes choose which peripheral takes a pin that GPIO does not own.

The pad control outputs (drive value, drive enable, pull-up, pull-down) are formed combinationally from the state registers and from the output and enable lanes of the four peripherals. A level register samples the pad input on every clock, so software can read the pin level whoever owns the pin. A read returns its data on `bus_rdata` one clock after the cycle in which `bus_rd_en` is high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After synchronous reset all pins are owned by GPIO, with output enable, output data, open-drain and pull-down cleared, pull-up set on every pin, and both select planes zero.
- R2: A write to a control's set address (word address 3k for control k, with k = 0 ownership, 1 output enable, 2 output data, 3 open-drain, 4 pull-up, 5 pull-down) sets the state bits where the write data is one and leaves the other bits unchanged.
- R3: A write to a control's clear address (3k+1) clears the state bits where the write data is one and leaves the other bits unchanged.
- R4: A read of a control's status address (3k+2) returns its state on `bus_rdata` one cycle after the read strobe. A read of an unmapped address (21 and above) returns zero.
- R5: Select plane low (address 18) and select plane high (address 19) are plain read/write registers. For pin n the code {high[n], low[n]} picks peripheral lane 0 to 3 (00 = first function, 01 = second, 10 = third, 11 = fourth). Lane f occupies bits f*32+n of `fn_oe` and `fn_dout`.
- R6: When GPIO owns a pin, the drive enable and drive value come from that pin's output-enable and output-data bits.
- R7: When a peripheral owns a pin, the drive enable and drive value come from the lane chosen by the pin's select code.
- R8: With open-drain on, a pin is driven only to low. `pad_out` is 0, and `pad_oe` is high only when the effective enable is high and the effective data is 0.
- R9: `pad_pd` follows the pull-down state. `pad_pu` is the pull-up state forced off wherever pull-down is on, so the two are never high together.
- R10: Address 20 returns the pad input level sampled by the clock, whether the pin is owned by GPIO or by a peripheral.
- R11: The output data state changes only through its set and clear addresses. Writes to any status address or to the level address leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | AW (5) | Word address |
| bus_wdata | input | NPIN (32) | Write data, bit n for pin n |
| bus_rdata | output | NPIN (32) | Registered read data |
| fn_oe | input | 4*NPIN | Drive enables of the four peripheral lanes |
| fn_dout | input | 4*NPIN | Drive values of the four peripheral lanes |
| pad_in | input | NPIN | Pad input level |
| pad_out | output | NPIN | Pad drive value |
| pad_oe | output | NPIN | Pad drive enable |
| pad_pu | output | NPIN | Pad pull-up enable |
| pad_pd | output | NPIN | Pad pull-down enable |

## Verification
The assertions assume that the bus carries at most one write per cycle and that the write address stays stable during the strobe. They also assume that the reset lasts at least one clock before the first bus access. The stimulus drives every bus strobe for exactly one clock from the falling edge, and never issues a read and a write together. The peripheral lanes and `pad_in` change only while the bus is idle, so every pad sample and every level read sees settled inputs.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NCTL  = 6;
  localparam int NFUNC = 4;
  localparam int SELW  = 2;

  localparam int CTL_OWN = 0;
  localparam int CTL_OE  = 1;
  localparam int CTL_DAT = 2;
  localparam int CTL_OD  = 3;
  localparam int CTL_PU  = 4;
  localparam int CTL_PD  = 5;

  // control k: set at 3k, clear at 3k+1, status at 3k+2
  localparam int ADR_SEL_LO = 3 * NCTL;
  localparam int ADR_SEL_HI = 3 * NCTL + 1;
  localparam int ADR_LVL    = 3 * NCTL + 2;

  function automatic logic ctl_rst_one(input int k);
    return (k == CTL_OWN) || (k == CTL_PU);
  endfunction
endpackage

// File: rtl/gpio_bank_w1sc.sv
module gpio_bank_w1sc #(
  parameter int   W       = 32,
  parameter logic RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_hit,
  input  logic         clr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= {W{RST_ONE}};
    else if (set_hit) q <= q | wdata;
    else if (clr_hit) q <= q & ~wdata;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [AW-1:0]              addr,
  input  logic [NPIN-1:0]            wdata,
  input  logic [NPIN-1:0]            pad_in,
  output logic [NCTL-1:0][NPIN-1:0]  ctl_q,
  output logic [NPIN-1:0]            sel_lo,
  output logic [NPIN-1:0]            sel_hi,
  output logic [NPIN-1:0]            rdata
);
  logic [NPIN-1:0] lvl_q;
  logic [NPIN-1:0] rd_nx;

  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    logic set_hit, clr_hit;
    assign set_hit = wr_en && (addr == AW'(3 * k));
    assign clr_hit = wr_en && (addr == AW'(3 * k + 1));
    gpio_bank_w1sc #(.W(NPIN), .RST_ONE(ctl_rst_one(k))) u_reg (
      .clk(clk), .rst(rst), .set_hit(set_hit), .clr_hit(clr_hit),
      .wdata(wdata), .q(ctl_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_lo <= '0;
      sel_hi <= '0;
      lvl_q  <= '0;
    end else begin
      lvl_q <= pad_in;
      if (wr_en && addr == AW'(ADR_SEL_LO)) sel_lo <= wdata;
      if (wr_en && addr == AW'(ADR_SEL_HI)) sel_hi <= wdata;
    end
  end

  always_comb begin
    rd_nx = '0;
    for (int k = 0; k < NCTL; k++)
      if (addr == AW'(3 * k + 2)) rd_nx = ctl_q[k];
    if (addr == AW'(ADR_SEL_LO)) rd_nx = sel_lo;
    if (addr == AW'(ADR_SEL_HI)) rd_nx = sel_hi;
    if (addr == AW'(ADR_LVL))    rd_nx = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nx;
  end
endmodule

// File: rtl/gpio_bank_padmux.sv
module gpio_bank_padmux
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0]       own,
  input  logic [NPIN-1:0]       oe,
  input  logic [NPIN-1:0]       dat,
  input  logic [NPIN-1:0]       od,
  input  logic [NPIN-1:0]       pu,
  input  logic [NPIN-1:0]       pd,
  input  logic [NPIN-1:0]       sel_lo,
  input  logic [NPIN-1:0]       sel_hi,
  input  logic [NFUNC*NPIN-1:0] fn_oe,
  input  logic [NFUNC*NPIN-1:0] fn_dout,
  output logic [NPIN-1:0]       pad_out,
  output logic [NPIN-1:0]       pad_oe,
  output logic [NPIN-1:0]       pad_pu,
  output logic [NPIN-1:0]       pad_pd
);
  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic [NFUNC-1:0] lane_oe, lane_d;
    logic [SELW-1:0]  code;
    logic             oe_e, d_e;
    for (genvar f = 0; f < NFUNC; f++) begin : g_lane
      assign lane_oe[f] = fn_oe[f*NPIN + n];
      assign lane_d[f]  = fn_dout[f*NPIN + n];
    end
    assign code       = {sel_hi[n], sel_lo[n]};
    assign oe_e       = own[n] ? oe[n]  : lane_oe[code];
    assign d_e        = own[n] ? dat[n] : lane_d[code];
    assign pad_out[n] = d_e & ~od[n];
    assign pad_oe[n]  = oe_e & ~(od[n] & d_e);
    assign pad_pd[n]  = pd[n];
    assign pad_pu[n]  = pu[n] & ~pd[n];
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr_en,
  input  logic                  bus_rd_en,
  input  logic [AW-1:0]         bus_addr,
  input  logic [NPIN-1:0]       bus_wdata,
  output logic [NPIN-1:0]       bus_rdata,
  input  logic [NFUNC*NPIN-1:0] fn_oe,
  input  logic [NFUNC*NPIN-1:0] fn_dout,
  input  logic [NPIN-1:0]       pad_in,
  output logic [NPIN-1:0]       pad_out,
  output logic [NPIN-1:0]       pad_oe,
  output logic [NPIN-1:0]       pad_pu,
  output logic [NPIN-1:0]       pad_pd
);
  logic [NCTL-1:0][NPIN-1:0] ctl_q;
  logic [NPIN-1:0] sel_lo, sel_hi;
  logic [NPIN-1:0] own_q, oe_q, dat_q, od_q, pu_q, pd_q;

  gpio_bank_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .pad_in(pad_in),
    .ctl_q(ctl_q), .sel_lo(sel_lo), .sel_hi(sel_hi), .rdata(bus_rdata)
  );

  assign own_q = ctl_q[CTL_OWN];
  assign oe_q  = ctl_q[CTL_OE];
  assign dat_q = ctl_q[CTL_DAT];
  assign od_q  = ctl_q[CTL_OD];
  assign pu_q  = ctl_q[CTL_PU];
  assign pd_q  = ctl_q[CTL_PD];

  gpio_bank_padmux #(.NPIN(NPIN)) u_pad (
    .own(own_q), .oe(oe_q), .dat(dat_q), .od(od_q), .pu(pu_q), .pd(pd_q),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .fn_oe(fn_oe), .fn_dout(fn_dout),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr_en,
  input logic [AW-1:0]   bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_pu,
  input logic [NPIN-1:0] pad_pd,
  input logic [NPIN-1:0] oe_q,
  input logic [NPIN-1:0] dat_q,
  input logic [NPIN-1:0] od_q
);
  a_r1_reset_pads: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '1 && pad_pd == '0));

  a_r2_oe_set: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == AW'(3 * CTL_OE)) |=>
      ((oe_q & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_oe_clr: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == AW'(3 * CTL_OE + 1)) |=>
      ((oe_q & $past(bus_wdata)) == '0));

  a_r8_od_never_high: assert property (@(posedge clk) disable iff (rst)
    (pad_out & od_q) == '0);

  a_r9_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  a_r11_dat_stat_ro: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == AW'(3 * CTL_DAT + 2)) |=> $stable(dat_q));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPIN(NPIN), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .oe_q(oe_q), .dat_q(dat_q), .od_q(od_q)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
  import gpio_bank_pkg::*;
  localparam int NPIN = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NPIN-1:0] bus_wdata = '0, bus_rdata;
  logic [NFUNC*NPIN-1:0] fn_oe = '0, fn_dout = '0;
  logic [NPIN-1:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NPIN(NPIN), .AW(AW)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [NPIN-1:0] m [NCTL];
  logic [NPIN-1:0] m_lo, m_hi;

  task automatic chk(string tag, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [NPIN-1:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [NPIN-1:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_stat(string tag);
    logic [NPIN-1:0] d;
    for (int k = 0; k < NCTL; k++) begin
      rd(3 * k + 2, d);
      chk(tag, d, m[k]);
    end
  endtask

  task automatic chk_pads(string tag);
    logic [NPIN-1:0] e_out, e_oe, e_pu, e_pd;
    #1;
    for (int n = 0; n < NPIN; n++) begin
      int c;
      logic o, dv, od;
      c  = 2 * int'(m_hi[n]) + int'(m_lo[n]);
      o  = m[CTL_OWN][n] ? m[CTL_OE][n]  : fn_oe[c * NPIN + n];
      dv = m[CTL_OWN][n] ? m[CTL_DAT][n] : fn_dout[c * NPIN + n];
      od = m[CTL_OD][n];
      e_out[n] = od ? 1'b0 : dv;
      e_oe[n]  = od ? (o && !dv) : o;
      e_pd[n]  = m[CTL_PD][n];
      e_pu[n]  = m[CTL_PD][n] ? 1'b0 : m[CTL_PU][n];
    end
    chk({tag, " out"}, pad_out, e_out);
    chk({tag, " oe"},  pad_oe,  e_oe);
    chk({tag, " pu"},  pad_pu,  e_pu);
    chk({tag, " pd"},  pad_pd,  e_pd);
  endtask

  task automatic mset(int k, logic [NPIN-1:0] d);
    wr(3 * k, d);
    m[k] = m[k] | d;
  endtask

  task automatic mclr(int k, logic [NPIN-1:0] d);
    wr(3 * k + 1, d);
    m[k] = m[k] & ~d;
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=finish");
    report();
  end

  initial begin
    logic [NPIN-1:0] d;
    logic [NPIN-1:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0001;
    pats[2] = 32'h8000_0000; pats[3] = 32'h5A3C_96E1;
    for (int k = 0; k < NCTL; k++) m[k] = ctl_rst_one(k) ? '1 : '0;
    m_lo = '0; m_hi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk_stat("R1 reset status");
    rd(ADR_SEL_LO, d); chk("R1 reset sel_lo", d, '0);
    rd(ADR_SEL_HI, d); chk("R1 reset sel_hi", d, '0);
    chk_pads("R1 reset pads");

    // R2 R3: set and clear every control with several patterns
    for (int k = 0; k < NCTL; k++) begin
      for (int p = 0; p < 4; p++) begin
        mclr(k, pats[p] ^ 32'h0F0F_F0F0);
        rd(3 * k + 2, d); chk("R3 clear", d, m[k]);
        mset(k, pats[p]);
        rd(3 * k + 2, d); chk("R2 set", d, m[k]);
      end
      mclr(k, '1);
      rd(3 * k + 2, d); chk("R3 clear all", d, '0);
      mset(k, 32'h0000_0000);
      rd(3 * k + 2, d); chk("R2 zero write no effect", d, '0);
    end
    // restore a mixed state
    mset(CTL_OWN, '1);
    mset(CTL_PU, 32'hFFFF_0000);

    // R4 R11: status and level addresses are read-only, unmapped reads zero
    mset(CTL_DAT, 32'h1234_5678);
    for (int k = 0; k < NCTL; k++) wr(3 * k + 2, 32'hDEAD_BEEF);
    wr(ADR_LVL, 32'hDEAD_BEEF);
    chk_stat("R11 status write ignored");
    for (int a = 21; a < 32; a++) begin
      rd(a, d); chk("R4 unmapped zero", d, '0);
    end

    // R5: select planes read/write
    wr(ADR_SEL_LO, 32'hA5A5_5A5A); m_lo = 32'hA5A5_5A5A;
    wr(ADR_SEL_HI, 32'h3C3C_C3C3); m_hi = 32'h3C3C_C3C3;
    rd(ADR_SEL_LO, d); chk("R5 sel_lo rw", d, m_lo);
    rd(ADR_SEL_HI, d); chk("R5 sel_hi rw", d, m_hi);

    // peripheral lanes with distinct patterns
    @(negedge clk);
    fn_dout = {32'h1234_5678, 32'hFF00_F00F, 32'h3C3C_0FF0, 32'hA5A5_A5A5};
    fn_oe   = {32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'hCCCC_3333, 32'h6666_9999};

    // R6: GPIO owns all pins
    mset(CTL_OE, 32'hFFFF_00FF);
    chk_pads("R6 gpio owner");
    mclr(CTL_DAT, 32'h00FF_FF00);
    chk_pads("R6 gpio data change");

    // R7: peripheral ownership, each uniform code then mixed
    mclr(CTL_OWN, '1);
    for (int c = 0; c < NFUNC; c++) begin
      wr(ADR_SEL_LO, (c & 1) ? '1 : '0); m_lo = (c & 1) ? '1 : '0;
      wr(ADR_SEL_HI, (c & 2) ? '1 : '0); m_hi = (c & 2) ? '1 : '0;
      chk_pads("R7 uniform code");
      chk("R7 lane pick", pad_out, fn_dout[c * NPIN +: NPIN]);
    end
    wr(ADR_SEL_LO, 32'h5555_5555); m_lo = 32'h5555_5555;
    wr(ADR_SEL_HI, 32'h3333_3333); m_hi = 32'h3333_3333;
    chk_pads("R7 mixed codes");
    mset(CTL_OWN, 32'hF0F0_00FF);
    chk_pads("R7 mixed ownership");

    // R8: open-drain on mixed owners and on GPIO outputs
    mset(CTL_OD, 32'h0FF0_FF0F);
    chk_pads("R8 open drain");
    mset(CTL_OWN, '1); mset(CTL_OE, '1); mset(CTL_OD, '1);
    mclr(CTL_DAT, '1); mset(CTL_DAT, 32'hAAAA_5555);
    chk_pads("R8 open drain gpio");
    chk("R8 oe where data low", pad_oe, 32'h5555_AAAA);
    mclr(CTL_OD, '1);

    // R9: pull combinations
    mclr(CTL_PU, '1); mclr(CTL_PD, '1);
    mset(CTL_PU, 32'hFF00_FF00); mset(CTL_PD, 32'hF0F0_F0F0);
    chk_pads("R9 pull priority");
    chk("R9 pu masked", pad_pu, 32'h0F00_0F00);

    // R10: level readback under both ownerships
    mclr(CTL_OWN, 32'hFFFF_0000);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); pad_in = pats[p];
      rd(ADR_LVL, d); chk("R10 level", d, pats[p]);
    end

    chk_stat("R2 final status");
    report();
  end
endmodule